// File: doc/BRIEF.md
# Byte-Writable Synchronous Flow-Through RAM

This block is a single-port synchronous RAM with a flow-through read path. On each rising clock edge it samples the address, the write data, a global write strobe, a byte-write qualifier, one strobe per byte lane and three chip enables. The chip enables have mixed polarity. A write updates the selected byte lanes on the edge that samples it. A read cycle keeps only the sampled address and cycle kind in registers. The stored word then passes combinationally to the data output in the cycle that follows the edge, with no extra output register.

A small cycle-kind state machine keeps the classification of the last sampled cycle. It has three states: `CYC_DESEL` (chip not selected), `CYC_READ` (selected and no write strobe effective) and `CYC_WRITE` (selected and at least one lane written). Each edge moves the machine to the state given by the inputs sampled on that edge. Every transition between any two of the three states is allowed, and each is named by its target: `to_desel`, `to_read` and `to_write`. The output is driven only in `CYC_READ`, and only while the asynchronous active-low output enable is low. Because the state is rebuilt on every edge, deselect takes effect after a single cycle.

The data output is split into a value bus `q` and a drive flag `q_oe`, for a pad or bus mux to use. While `q_oe` is low, `q` is held at zero and stands for a high-impedance bus.

Top module: `flowthru_byte_ram`

## Requirements
- R1: The first clock edge with `rst` high sets the cycle state to `CYC_DESEL`. In the cycle after that edge, `q_oe` is 0 and `q` is 0.
- R2: When `gw_n` is 0 on a selected edge, all four byte lanes of `addr` take `d`, whatever the values of `bwe_n` and `bw_n`.
- R3: When `gw_n` is 1, lane i (bits 8i+7..8i of the word) is written only if `bwe_n` is 0 and `bw_n[i]` is 0. Lanes that are not written keep their contents, and with `bwe_n` at 1 no lane is written.
- R4: A single write may update any of the 16 combinations of lanes.
- R5: After a selected read edge with address A, `q` equals the stored word at A during the following cycle, with no additional clock delay.
- R6: The chip is selected only when `ce_n`=0, `ce2`=1 and `ce2_n`=0. In every other combination the edge writes nothing.
- R7: In the cycle after an edge that samples the chip deselected, `q_oe` is 0.
- R8: A selected edge with no effective write strobe is a read cycle. This includes `bwe_n`=0 with all `bw_n` at 1, and `bwe_n`=1 with any `bw_n`.
- R9: `q_oe` is 1 exactly when the last edge was a selected read and `oe_n` is currently 0. `oe_n` acts without waiting for a clock. When `q_oe` is 0, `q` is 0.
- R10: In the cycle after a write edge, `q_oe` is 0.
- R11: A read of an address that was written on the previous edge returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the cycle state |
| addr | input | ADDR_W | Word address |
| d | input | LANES*LANE_W | Write data |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | LANES | Per-lane write strobes, active low |
| ce_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| q | output | LANES*LANE_W | Read data, zero when not driven |
| q_oe | output | 1 | Read data is being driven |

## Verification
The global write strobe and the per-lane strobes can arrive on the same edge. The first sweep asserts `gw_n` together with the qualifier and a partial strobe pattern, so that the global write must win. The sweep that follows reads back every lane of every address and compares each word with a shadow memory. The bench also writes an address on one edge and reads it on the next. The flow-through output must then show the merged word, which is computed in the bench from the lane mask, the old word and the new data.

// File: rtl/flowram_pkg.sv
package flowram_pkg;
    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/flowram_ctl.sv
module flowram_ctl
    import flowram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    output logic [LANES-1:0]  lane_we,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rd_en
);
    cyc_e cyc_q;
    cyc_e cyc_d;
    logic sel;

    // chip select needs all three enables active
    assign sel = !ce_n && ce2 && !ce2_n;

    // lane write enables: global write overrides qualified strobes
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_we[i] = sel && (!gw_n || (!bwe_n && !bw_n[i]));
        end
    end

    // next cycle kind: to_desel / to_write / to_read
    always_comb begin
        if (!sel) begin
            cyc_d = CYC_DESEL;
        end else if (|lane_we) begin
            cyc_d = CYC_WRITE;
        end else begin
            cyc_d = CYC_READ;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= CYC_DESEL;
            addr_q <= '0;
        end else begin
            cyc_q  <= cyc_d;
            addr_q <= addr;
        end
    end

    // outputs from state
    always_comb begin
        rd_en = 1'b0;
        unique case (cyc_q)
            CYC_DESEL: rd_en = 1'b0;
            CYC_READ:  rd_en = 1'b1;
            CYC_WRITE: rd_en = 1'b0;
            default:   rd_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/flowram_lane.sv
module flowram_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // flow-through read from registered address
    assign rdata = store[raddr];
endmodule

// File: rtl/flowram_out.sv
module flowram_out #(
    parameter int WORD_W = 32
) (
    input  logic              rd_en,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] q,
    output logic              q_oe
);
    assign q_oe = rd_en && !oe_n;
    assign q    = q_oe ? word : '0;
endmodule

// File: rtl/flowthru_byte_ram.sv
module flowthru_byte_ram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] d,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    ce_n,
    input  logic                    ce2,
    input  logic                    ce2_n,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_oe
);
    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_en;
    logic [WORD_W-1:0] word;

    flowram_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk(clk), .rst(rst), .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
        .lane_we(lane_we), .addr_q(addr_q), .rd_en(rd_en)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        flowram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk(clk), .we(lane_we[g]), .waddr(addr),
            .wdata(d[g*LANE_W +: LANE_W]), .raddr(addr_q),
            .rdata(word[g*LANE_W +: LANE_W])
        );
    end

    flowram_out #(.WORD_W(WORD_W)) u_out (
        .rd_en(rd_en), .oe_n(oe_n), .word(word), .q(q), .q_oe(q_oe)
    );
endmodule

// File: rtl/flowram_chk.sv
module flowram_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    gw_n,
    input logic                    bwe_n,
    input logic [LANES-1:0]        bw_n,
    input logic                    ce_n,
    input logic                    ce2,
    input logic                    ce2_n,
    input logic                    oe_n,
    input logic [LANES*LANE_W-1:0] q,
    input logic                    q_oe
);
    logic chip_on;
    logic any_wr;
    assign chip_on = !ce_n && ce2 && !ce2_n;
    assign any_wr  = !gw_n || (!bwe_n && (bw_n != '1));

    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !q_oe);

    assert_desel_R7: assert property (@(posedge clk) disable iff (rst)
        !chip_on |=> !q_oe);

    assert_write_nodrive_R10: assert property (@(posedge clk) disable iff (rst)
        (chip_on && any_wr) |=> !q_oe);

    assert_drive_src_R8: assert property (@(posedge clk) disable iff (rst)
        q_oe |-> $past(chip_on && !any_wr));

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (rst)
        q_oe |-> !oe_n);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !q_oe |-> (q == '0));
endmodule

bind flowthru_byte_ram flowram_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst(rst), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .oe_n(oe_n), .q(q), .q_oe(q_oe)
);

// File: tb/tb_flowthru_byte_ram.sv
`timescale 1ns/1ps
module tb_flowthru_byte_ram;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [31:0]   d = '0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0, oe_n = 1'b0;
    logic [31:0]   q;
    logic          q_oe;

    int checks = 0;
    int fails = 0;
    logic [31:0] shadow [DEPTH];

    flowthru_byte_ram #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) dut (
        .clk(clk), .rst(rst), .addr(addr), .d(d), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .oe_n(oe_n),
        .q(q), .q_oe(q_oe)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat_a(input int a);
        logic [7:0] b = 8'(a);
        return {b + 8'h11, b ^ 8'hA5, ~b, 8'(b * 3)};
    endfunction

    function automatic logic [31:0] pat_b(input int a);
        logic [7:0] b = 8'(a);
        return {b ^ 8'h3C, 8'(b + 8'h70), 8'(b * 5), b ^ 8'hFF};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    // drive one cycle at a falling edge; the outputs are sampled at the next falling edge
    task automatic step(input logic [2:0] ces, input int a, input logic [31:0] dv,
                        input logic g, input logic be, input logic [3:0] bw);
        {ce_n, ce2, ce2_n} = ces;
        addr = AW'(a);
        d = dv;
        gw_n = g;
        bwe_n = be;
        bw_n = bw;
        @(negedge clk);
    endtask

    localparam logic [2:0] SEL = 3'b010;

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 q_oe in reset", {31'd0, q_oe}, 32'd0);
        chk("R1 q in reset", q, 32'd0);
        rst = 1'b0;

        // R2: global write with qualifier and partial strobes, which must be overridden
        for (int a = 0; a < DEPTH; a++) begin
            step(SEL, a, pat_a(a), 1'b0, 1'b0, 4'b1010);
            shadow[a] = pat_a(a);
            chk("R10 no drive after write", {31'd0, q_oe}, 32'd0);
        end
        // R5: read sweep
        for (int a = 0; a < DEPTH; a++) begin
            step(SEL, a, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'h0);
            chk("R2/R5 read data", q, shadow[a]);
            chk("R8 read drives", {31'd0, q_oe}, 32'd1);
        end
        // R3/R4/R11: every lane mask, then a read on the next edge
        for (int a = 0; a < DEPTH; a++) begin
            logic [3:0] m = 4'(a);
            step(SEL, a, pat_b(a), 1'b1, 1'b0, ~m);
            if (m == 4'd0) chk("R8 strobes idle gives read", q, shadow[a]);
            shadow[a] = merge(shadow[a], pat_b(a), m);
            step(SEL, a, 32'h0, 1'b1, 1'b1, 4'hF);
            chk("R3/R4/R11 merged readback", q, shadow[a]);
        end
        // R3/R8: with the qualifier high, the strobes are ignored and the cycle is a read
        for (int a = 0; a < 8; a++) begin
            step(SEL, a, 32'h1234_5678, 1'b1, 1'b1, 4'h0);
            chk("R8 unqualified strobes read", {31'd0, q_oe}, 32'd1);
            chk("R3 unqualified strobes no write", q, shadow[a]);
        end
        // R6/R7: every non-selecting enable combination
        for (int c = 0; c < 8; c++) begin
            if (3'(c) == SEL) continue;
            step(SEL, c, 32'h0, 1'b1, 1'b1, 4'hF);
            step(3'(c), c, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'h0);
            chk("R7 deselect one cycle", {31'd0, q_oe}, 32'd0);
            step(SEL, c, 32'h0, 1'b1, 1'b1, 4'hF);
            chk("R6 deselected write ignored", q, shadow[c]);
        end
        // R9: output enable acts between edges
        oe_n = 1'b1;
        step(SEL, 5, 32'h0, 1'b1, 1'b1, 4'hF);
        chk("R9 oe high no drive", {31'd0, q_oe}, 32'd0);
        chk("R9 q zero undriven", q, 32'd0);
        oe_n = 1'b0;
        #1;
        chk("R9 oe async drive", {31'd0, q_oe}, 32'd1);
        chk("R9 oe async data", q, shadow[5]);
        // R11: two back-to-back global writes to one address, then a read
        step(SEL, 9, 32'hA1B2_C3D4, 1'b0, 1'b1, 4'hF);
        step(SEL, 9, 32'h0F1E_2D3C, 1'b0, 1'b1, 4'hF);
        shadow[9] = 32'h0F1E_2D3C;
        step(SEL, 9, 32'h0, 1'b1, 1'b1, 4'hF);
        chk("R11 latest write read", q, shadow[9]);
        // R1: reset again
        rst = 1'b1;
        step(SEL, 9, 32'h0, 1'b1, 1'b1, 4'hF);
        chk("R1 reset clears drive", {31'd0, q_oe}, 32'd0);
        rst = 1'b0;
        summary();
    end
endmodule